// File: doc/BRIEF.md
# Sum-of-Products Output Macrocell

This block is one output cell of a programmable sum-of-products logic array. It forms up to `N_PT` product terms from the true and inverted forms of the dedicated inputs and the feedback lines. Any literal may be enabled in each term. The enabled terms are ORed into one sum. The sum drives either the pin directly (combinational) or a D register (registered), and an optional inversion sets the active level. A separate product term drives the pin's output enable. The cell returns one feedback line to the array: the inverted register output in registered mode, or the level seen on the pin in combinational mode.

Two product terms are shared by every register of the device and arrive as evaluated bits. One clears the register at once, without waiting for a clock. The other sets the register at the next edge. A test preload forces any chosen register value at a clock edge. A synchronous power-up reset clears the register. The programming pattern is applied on static configuration ports. A term count outside 8 to 16 is rejected when the design is built.

Top module: `pld_macrocell`

## Requirements
- R1: A product term is 1 only when it is enabled (`pt_used` bit set) and every literal selected by its true mask (signal must be 1) and its complement mask (signal must be 0) holds. A term with no literal selected evaluates to 1. A disabled term gives 0. A term that selects both the true and complement literal of the same signal gives 0.
- R2: The sum is the OR of all `N_PT` product terms. Bit k of `pt_used` and slice `[k*NSIG +: NSIG]` of the masks belong to term k. The array signal vector is `{fb_in, din}`, with `din[0]` at index 0.
- R3: With `cfg_reg`=0, `pin_out` equals the sum when `cfg_inv`=0 and its inverse when `cfg_inv`=1, in the same cycle.
- R4: With `cfg_reg`=1, each clock edge with no override loads the sum into the register. `pin_out` then shows the register value when `cfg_inv`=0 and its inverse when `cfg_inv`=1.
- R5: `pin_oe` equals the output-enable product term formed from `oe_true`/`oe_comp` over the same signal vector. An empty OE term gives 1.
- R6: `fb_out` is the inverted register value when `cfg_reg`=1, and equals `pin_in` when `cfg_reg`=0.
- R7: A clock edge with `rst_n`=0 clears the register. `pin_out` then reads 0 for active-high and 1 for active-low registered output.
- R8: While `ar_term` is 1, the register is 0. It clears as soon as `ar_term` rises, with no clock edge, and it wins over every other control.
- R9: A clock edge with `sp_term`=1, no reset, no clear and no preload sets the register to 1, whatever the sum.
- R10: A clock edge with `preload_en`=1, no reset and no clear loads `preload_val` into the register, over both the preset and the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| din | input | N_IN (12) | Dedicated array inputs |
| fb_in | input | N_FB (10) | Feedback lines from all cells |
| pt_true | input | N_PT*NSIG | True-literal masks, one slice per term |
| pt_comp | input | N_PT*NSIG | Complement-literal masks |
| pt_used | input | N_PT (8) | Per-term enable |
| oe_true | input | NSIG (22) | OE term true-literal mask |
| oe_comp | input | NSIG (22) | OE term complement-literal mask |
| cfg_reg | input | 1 | 1 = registered, 0 = combinational |
| cfg_inv | input | 1 | 1 = active-low output |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous preset term |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value forced by preload |
| pin_in | input | 1 | Level observed on the pin |
| pin_out | output | 1 | Output data to the pin driver |
| pin_oe | output | 1 | Output enable to the pin driver |
| fb_out | output | 1 | Feedback returned to the array |

## Verification
The clocked properties assume that `ar_term` never changes within the same instant as a rising clock. The stimulus meets this by moving every input, including the clear term, at the falling edge or partway into the low phase. The properties also assume that the configuration and mask ports hold steady across the edge they describe. The bench changes them only at falling edges, and it samples outputs one step after those moves. The combinational checks assume the masks are at known values from time zero, so every bench drive starts at zero.

// File: rtl/pld_mc_pkg.sv
// Package: shared limits and configuration type for the output macrocell.
// Assumes: nothing; pure declarations.
package pld_mc_pkg;
    localparam int PT_MIN = 8;
    localparam int PT_MAX = 16;

    // Output configuration of one cell.
    typedef struct packed {
        logic registered;  // 1: sum passes through the D register
        logic active_low;  // 1: pin shows the inverse
    } mc_cfg_t;
endpackage

// File: rtl/pld_pterm.sv
// Module: one product term of the AND array.
// Does: ANDs every literal selected by the true and complement masks.
// Assumes: masks are static configuration; an empty enabled term is 1.
module pld_pterm #(
    parameter int NSIG = 22
) (
    input  logic [NSIG-1:0] sig,
    input  logic [NSIG-1:0] t_en,
    input  logic [NSIG-1:0] c_en,
    input  logic            used,
    output logic            term
);
    logic true_ok;
    logic comp_ok;

    // Every selected true literal must be 1, every selected complement literal 0.
    always_comb begin
        true_ok = &(sig | ~t_en);
        comp_ok = &(~sig | ~c_en);
        term    = used & true_ok & comp_ok;
    end

    // A term holding a signal and its inverse can never be true (R1).
    always_comb begin
        if (|(t_en & c_en))
            assert_contradiction_R1: assert (term == 1'b0);
    end
endmodule

// File: rtl/pld_mc_reg.sv
// Module: macrocell D register with clear, reset, preload and preset.
// Does: priority clear > power-up reset > preload > preset > sum.
// Assumes: ar_clr never changes in the same instant as a rising clk.
module pld_mc_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ar_clr,
    input  logic pl_en,
    input  logic pl_val,
    input  logic sp_set,
    input  logic d,
    output logic q
);
    // Register update; the clear term acts without a clock.
    always_ff @(posedge clk or posedge ar_clr) begin
        if (ar_clr)
            q <= 1'b0;
        else if (!rst_n)
            q <= 1'b0;
        else if (pl_en)
            q <= pl_val;
        else if (sp_set)
            q <= 1'b1;
        else
            q <= d;
    end

    // Power-up reset clears the register (R7).
    assert_reset_R7: assert property (@(posedge clk)
        !rst_n |=> (q == 1'b0));

    // Clear term holds the register low (R8).
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ar_clr |-> (q == 1'b0));

    // Preload wins over preset and sum (R10).
    assert_preload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_en && !ar_clr) |=> (ar_clr || !rst_n || q == $past(pl_val)));

    // Preset sets the register (R9).
    assert_preset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_set && !pl_en && !ar_clr) |=> (ar_clr || !rst_n || q));

    // Plain edge loads the sum (R4).
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_set && !pl_en && !ar_clr) |=> (ar_clr || !rst_n || q == $past(d)));
endmodule

// File: rtl/pld_mc_outsel.sv
// Module: output and feedback select of the macrocell.
// Does: picks register or sum, applies polarity, picks the feedback source.
// Assumes: cfg is static while the cell runs.
module pld_mc_outsel
    import pld_mc_pkg::*;
(
    input  mc_cfg_t cfg,
    input  logic    sum,
    input  logic    q,
    input  logic    pin_in,
    output logic    pin_out,
    output logic    fb_out
);
    logic core;

    // Output level: chosen source, then optional inversion.
    always_comb begin
        core    = cfg.registered ? q : sum;
        pin_out = cfg.active_low ? ~core : core;
    end

    // Feedback: inverted register, or the pin level in combinational mode.
    always_comb begin
        fb_out = cfg.registered ? ~q : pin_in;
    end
endmodule

// File: rtl/pld_macrocell.sv
// Module: top of one sum-of-products output macrocell.
// Does: N_PT product terms ORed, register/combinational output with polarity,
//       output-enable term and feedback line.
// Assumes: masks and cfg bits are static configuration; shared clear and
//          preset terms arrive already evaluated.
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int N_IN = 12,
    parameter int N_FB = 10,
    parameter int N_PT = 8,
    localparam int NSIG = N_IN + N_FB,
    localparam int MASK_W = N_PT * NSIG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   din,
    input  logic [N_FB-1:0]   fb_in,
    input  logic [MASK_W-1:0] pt_true,
    input  logic [MASK_W-1:0] pt_comp,
    input  logic [N_PT-1:0]   pt_used,
    input  logic [NSIG-1:0]   oe_true,
    input  logic [NSIG-1:0]   oe_comp,
    input  logic              cfg_reg,
    input  logic              cfg_inv,
    input  logic              ar_term,
    input  logic              sp_term,
    input  logic              preload_en,
    input  logic              preload_val,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_out
);
    logic [NSIG-1:0] sig;
    logic [N_PT-1:0] terms;
    logic            sum;
    logic            q;
    mc_cfg_t         cfg;

    // Term count must stay inside the supported range.
    initial begin
        assert_ptcount_R2: assert (N_PT >= PT_MIN && N_PT <= PT_MAX);
    end

    // Array signal vector and configuration record.
    always_comb begin
        sig            = {fb_in, din};
        cfg.registered = cfg_reg;
        cfg.active_low = cfg_inv;
    end

    // One evaluator per product term.
    for (genvar k = 0; k < N_PT; k++) begin : g_pt
        pld_pterm #(.NSIG(NSIG)) u_pt (
            .sig  (sig),
            .t_en (pt_true[k*NSIG +: NSIG]),
            .c_en (pt_comp[k*NSIG +: NSIG]),
            .used (pt_used[k]),
            .term (terms[k])
        );
    end

    // Output-enable term, always enabled.
    pld_pterm #(.NSIG(NSIG)) u_oe (
        .sig  (sig),
        .t_en (oe_true),
        .c_en (oe_comp),
        .used (1'b1),
        .term (pin_oe)
    );

    // OR plane.
    always_comb begin
        sum = |terms;
    end

    pld_mc_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .ar_clr (ar_term),
        .pl_en  (preload_en),
        .pl_val (preload_val),
        .sp_set (sp_term),
        .d      (sum),
        .q      (q)
    );

    pld_mc_outsel u_out (
        .cfg     (cfg),
        .sum     (sum),
        .q       (q),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .fb_out  (fb_out)
    );

    // Disabled terms leave the sum at 0 (R1).
    assert_unused_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_used == '0) |-> !sum);

    // Combinational pin follows the OR plane (R3).
    assert_comb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_reg |-> (pin_out == (sum ^ cfg_inv)));

    // Registered feedback is the complement of the register seen at the pin (R6).
    assert_fb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reg |-> (fb_out == ~(pin_out ^ cfg_inv)));
endmodule

// File: tb/pld_macrocell_test.sv
// Bench: directed scenarios, one task each, against a behavioural SOP model.
module pld_macrocell_test;
    localparam int N_IN = 12;
    localparam int N_FB = 10;
    localparam int N_PT = 10;
    localparam int NSIG = N_IN + N_FB;
    localparam int MASK_W = N_PT * NSIG;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_IN-1:0]   din = '0;
    logic [N_FB-1:0]   fb_in = '0;
    logic [MASK_W-1:0] pt_true = '0;
    logic [MASK_W-1:0] pt_comp = '0;
    logic [N_PT-1:0]   pt_used = '0;
    logic [NSIG-1:0]   oe_true = '0;
    logic [NSIG-1:0]   oe_comp = '0;
    logic              cfg_reg = 1'b0;
    logic              cfg_inv = 1'b0;
    logic              ar_term = 1'b0;
    logic              sp_term = 1'b0;
    logic              preload_en = 1'b0;
    logic              preload_val = 1'b0;
    logic              pin_in = 1'b0;
    logic              pin_out;
    logic              pin_oe;
    logic              fb_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pld_macrocell #(.N_IN(N_IN), .N_FB(N_FB), .N_PT(N_PT)) uut (
        .clk(clk), .rst_n(rst_n), .din(din), .fb_in(fb_in),
        .pt_true(pt_true), .pt_comp(pt_comp), .pt_used(pt_used),
        .oe_true(oe_true), .oe_comp(oe_comp), .cfg_reg(cfg_reg),
        .cfg_inv(cfg_inv), .ar_term(ar_term), .sp_term(sp_term),
        .preload_en(preload_en), .preload_val(preload_val), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_term(input logic [NSIG-1:0] s,
                                        input logic [NSIG-1:0] t,
                                        input logic [NSIG-1:0] c);
        logic r = 1'b1;
        for (int i = 0; i < NSIG; i++) begin
            if (t[i] && !s[i]) r = 1'b0;
            if (c[i] && s[i])  r = 1'b0;
        end
        return r;
    endfunction

    function automatic logic model_sum();
        logic r = 1'b0;
        for (int k = 0; k < N_PT; k++)
            if (pt_used[k] && model_term({fb_in, din}, pt_true[k*NSIG +: NSIG],
                                         pt_comp[k*NSIG +: NSIG]))
                r = 1'b1;
        return r;
    endfunction

    task automatic gen_program();
        pt_true = '0;
        pt_comp = '0;
        oe_true = '0;
        oe_comp = '0;
        for (int k = 0; k < N_PT; k++) begin
            int n = int'($urandom_range(1, 3));
            for (int j = 0; j < n; j++) begin
                int idx = int'($urandom_range(0, NSIG - 1));
                if ($urandom_range(0, 1) == 1) pt_true[k*NSIG + idx] = 1'b1;
                else                           pt_comp[k*NSIG + idx] = 1'b1;
            end
        end
        pt_used = N_PT'($urandom);
        if ($urandom_range(0, 1) == 1) oe_true[$urandom_range(0, NSIG - 1)] = 1'b1;
        else                           oe_comp[$urandom_range(0, NSIG - 1)] = 1'b1;
    endtask

    task automatic gen_inputs();
        din    = N_IN'($urandom);
        fb_in  = N_FB'($urandom);
        pin_in = 1'($urandom);
    endtask

    // Power-up reset: register low, pin follows polarity.
    task automatic t_reset();
        cfg_reg = 1'b1;
        cfg_inv = 1'b0;
        rst_n   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R7 reset active-high pin", pin_out, 1'b0);
        chk("R6 reset feedback", fb_out, 1'b1);
        cfg_inv = 1'b1; #1;
        chk("R7 reset active-low pin", pin_out, 1'b1);
        rst_n = 1'b1;
    endtask

    // Corner terms: contradiction, empty, disabled.
    task automatic t_special_terms();
        @(negedge clk);
        cfg_reg = 1'b0;
        cfg_inv = 1'b0;
        pt_true = '0;
        pt_comp = '0;
        pt_used = '0;
        din     = '1;
        #1;
        chk("R1 all terms disabled", pin_out, 1'b0);
        pt_used[3] = 1'b1;
        #1;
        chk("R1 empty enabled term", pin_out, 1'b1);
        pt_true[3*NSIG + 5] = 1'b1;
        pt_comp[3*NSIG + 5] = 1'b1;
        #1;
        chk("R1 true and complement of one input", pin_out, 1'b0);
        pt_used = '0;
        pt_used[N_PT-1] = 1'b1;
        pt_comp[(N_PT-1)*NSIG + 0] = 1'b1;
        din[0] = 1'b0;
        #1;
        chk("R2 last term alone", pin_out, 1'b1);
        oe_true = '0;
        oe_comp = '0;
        #1;
        chk("R5 empty OE term", pin_oe, 1'b1);
    endtask

    // Random programs in combinational mode, both polarities.
    task automatic t_comb_random();
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            cfg_reg = 1'b0;
            cfg_inv = 1'(n % 2);
            if (n % 4 == 0) gen_program();
            gen_inputs();
            #1;
            chk("R3 combinational pin vs model", pin_out, model_sum() ^ cfg_inv);
            chk("R5 OE term vs model", pin_oe, model_term({fb_in, din}, oe_true, oe_comp));
            chk("R6 combinational feedback", fb_out, pin_in);
        end
    endtask

    // Random programs in registered mode.
    task automatic t_reg_random();
        for (int n = 0; n < 60; n++) begin
            logic exp;
            @(negedge clk);
            cfg_reg = 1'b1;
            cfg_inv = 1'(n % 2);
            if (n % 4 == 0) gen_program();
            gen_inputs();
            #1;
            exp = model_sum();
            @(negedge clk); #1;
            chk("R4 registered pin vs model", pin_out, exp ^ cfg_inv);
            chk("R6 registered feedback", fb_out, ~exp);
        end
    endtask

    // Preset and preload priorities.
    task automatic t_preset_preload();
        @(negedge clk);
        cfg_reg = 1'b1;
        cfg_inv = 1'b0;
        pt_used = '0;
        sp_term = 1'b1;
        @(negedge clk); #1;
        chk("R9 preset with zero sum", pin_out, 1'b1);
        preload_en  = 1'b1;
        preload_val = 1'b0;
        @(negedge clk); #1;
        chk("R10 preload 0 over preset", pin_out, 1'b0);
        sp_term     = 1'b0;
        preload_val = 1'b1;
        @(negedge clk); #1;
        chk("R10 preload 1 over zero sum", pin_out, 1'b1);
        preload_en = 1'b0;
        @(negedge clk); #1;
        chk("R4 sum reloads after preload", pin_out, 1'b0);
    endtask

    // Asynchronous clear without a clock edge.
    task automatic t_async_clear();
        @(negedge clk);
        cfg_reg = 1'b1;
        cfg_inv = 1'b0;
        sp_term = 1'b1;
        @(negedge clk); #1;
        chk("R9 preset before clear", pin_out, 1'b1);
        #4;
        ar_term = 1'b1;
        #1;
        chk("R8 clear without clock", pin_out, 1'b0);
        preload_en  = 1'b1;
        preload_val = 1'b1;
        @(negedge clk); #1;
        chk("R8 clear over preload and preset", pin_out, 1'b0);
        ar_term    = 1'b0;
        preload_en = 1'b0;
        @(negedge clk); #1;
        chk("R9 preset after clear released", pin_out, 1'b1);
        sp_term = 1'b0;
    endtask

    initial begin
        t_reset();
        t_special_terms();
        t_comb_random();
        t_reg_random();
        t_preset_preload();
        t_async_clear();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule